// File: doc/BRIEF.md
# Shared-Memory Collision Arbiter

This block stands between a set of requesters and one shared word memory. In any cycle each requester may issue one read or one write, and several of them may name the same word. The memory holds one word per address. Requests that touch different words all proceed in parallel. Requests that meet on one word are settled by two selectors. A two-bit discipline input says whether same-word reads and same-word writes may proceed together. A policy input says how a group of concurrent writers to one word is turned into the value that gets stored.

Each requester gets a one-cycle-late response: a grant or a deny, a flag saying that its access met another access of the same kind on the same word, and read data. Reads always see the word as it was before any write made in the same cycle. The lowest requester index has the highest priority.

Top module: `shmem_arbiter`

## Requirements
- R1: While rst_ni is low, every output is zero and every memory word is cleared to zero.
- R2: Requests are sampled on a rising clock edge and the responses appear after that edge. A requester that asserts both rd_i and wr_i is treated as a writer. An idle requester gets no grant, no deny and no conflict flag. Grant and deny are never both set.
- R3: A granted read returns the word's value from before any write committed in the same cycle. Accesses to distinct words are all granted.
- R4: conflict_o[i] is set when requester i's read (or write) shares its address with at least one other read (or write) in the same cycle. Every deny comes with a conflict flag.
- R5: mode_i bit 0 = 0 makes reads exclusive: among the readers of one word, only the lowest index is granted, and the others are denied with rdata_o 0. With bit 0 = 1, all readers are granted.
- R6: mode_i bit 1 = 0 makes writes exclusive: among the writers of one word, only the lowest index is granted and stored, and the others are denied.
- R7: With mode_i bit 1 = 1 and policy_i 0 (or any code from 5 to 7), all colliding writers are granted and the lowest index's data is stored.
- R8: With mode_i bit 1 = 1 and policy_i 1, the data is stored and all writers are granted only if every colliding writer presents equal data. Otherwise the word is unchanged and all of them are denied.
- R9: With mode_i bit 1 = 1, policy_i 2 stores the unsigned maximum of the colliding data and policy_i 3 stores the unsigned minimum. All writers are granted.
- R10: With mode_i bit 1 = 1 and policy_i 4, the stored value is the sum of the colliding data modulo 2^DATA_W. All writers are granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Discipline: bit 0 allows concurrent reads, bit 1 allows concurrent writes |
| policy_i | input | 3 | Resolution of concurrent writes: 0 priority, 1 common value, 2 max, 3 min, 4 sum |
| rd_i | input | NUM_REQ | Per-requester read request |
| wr_i | input | NUM_REQ | Per-requester write request |
| addr_i | input | NUM_REQ*ADDR_W | Word address of each requester, requester i in slice i |
| wdata_i | input | NUM_REQ*DATA_W | Write data of each requester |
| grant_o | output | NUM_REQ | Access was performed |
| deny_o | output | NUM_REQ | Access was refused |
| conflict_o | output | NUM_REQ | Access met a same-kind access to the same word |
| rdata_o | output | NUM_REQ*DATA_W | Read data, zero unless a read was granted |

## Verification
Directed collisions run in every discipline and policy combination, with all four requesters on one word. The write data is chosen distinct, equal, or carried across the top bit, which separates priority, common-value, max, min and wrapping sum. A mixed cycle has a reader and writers on the same word. It separates pre-write read data from post-write read data, and shows that a read beside a write is not counted as a conflict. Random traffic then uses only four addresses and a narrow data range, so that partial groups, equal-data groups and groups of two or three writers occur often. It is compared every cycle against a behavioural model of all four outputs.

// File: rtl/shmem_arb_pkg.sv
package shmem_arb_pkg;
  localparam int POL_W    = 3;
  localparam int MODE_W   = 2;
  localparam int MODE_CRD = 0;  // concurrent read allowed
  localparam int MODE_CWR = 1;  // concurrent write allowed

  typedef enum logic [POL_W-1:0] {
    POL_PRIO   = 3'd0,
    POL_COMMON = 3'd1,
    POL_MAX    = 3'd2,
    POL_MIN    = 3'd3,
    POL_SUM    = 3'd4
  } policy_e;
endpackage

// File: rtl/shmem_collide.sv
module shmem_collide #(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 4
) (
  input  logic [NUM_REQ-1:0]                     rd_v_i,
  input  logic [NUM_REQ-1:0]                     wr_v_i,
  input  logic [NUM_REQ-1:0][ADDR_W-1:0]         addr_i,
  output logic [NUM_REQ-1:0]                     rd_first_o,
  output logic [NUM_REQ-1:0]                     rd_coll_o,
  output logic [NUM_REQ-1:0]                     wr_first_o,
  output logic [NUM_REQ-1:0]                     wr_coll_o,
  output logic [NUM_REQ-1:0][NUM_REQ-1:0]        wr_peer_o
);
  always_comb begin
    rd_first_o = '1;
    rd_coll_o  = '0;
    wr_first_o = '1;
    wr_coll_o  = '0;
    wr_peer_o  = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      for (int j = 0; j < NUM_REQ; j++) begin
        // peer mask includes the requester itself
        if (wr_v_i[i] && wr_v_i[j] && (addr_i[i] == addr_i[j])) wr_peer_o[i][j] = 1'b1;
        if (j != i) begin
          if (rd_v_i[i] && rd_v_i[j] && (addr_i[i] == addr_i[j])) begin
            rd_coll_o[i] = 1'b1;
            if (j < i) rd_first_o[i] = 1'b0;
          end
          if (wr_v_i[i] && wr_v_i[j] && (addr_i[i] == addr_i[j])) begin
            wr_coll_o[i] = 1'b1;
            if (j < i) wr_first_o[i] = 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/shmem_merge.sv
module shmem_merge
  import shmem_arb_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int DATA_W  = 16,
  parameter int LEAD    = 0
) (
  input  logic [NUM_REQ-1:0]              peer_i,
  input  logic [NUM_REQ-1:0][DATA_W-1:0]  wdata_i,
  input  policy_e                         policy_i,
  output logic [DATA_W-1:0]               value_o,
  output logic                            same_o
);
  logic [DATA_W-1:0] max_q, min_q, sum_q;

  always_comb begin
    max_q  = wdata_i[LEAD];
    min_q  = wdata_i[LEAD];
    sum_q  = '0;
    same_o = 1'b1;
    for (int j = 0; j < NUM_REQ; j++) begin
      if (peer_i[j]) begin
        if (wdata_i[j] > max_q) max_q = wdata_i[j];
        if (wdata_i[j] < min_q) min_q = wdata_i[j];
        sum_q = sum_q + wdata_i[j];
        if (wdata_i[j] != wdata_i[LEAD]) same_o = 1'b0;
      end
    end
    case (policy_i)
      POL_MAX: value_o = max_q;
      POL_MIN: value_o = min_q;
      POL_SUM: value_o = sum_q;
      default: value_o = wdata_i[LEAD];  // group lead is its lowest index
    endcase
  end
endmodule

// File: rtl/shmem_arbiter.sv
module shmem_arbiter
  import shmem_arb_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [MODE_W-1:0]           mode_i,
  input  logic [POL_W-1:0]            policy_i,
  input  logic [NUM_REQ-1:0]          rd_i,
  input  logic [NUM_REQ-1:0]          wr_i,
  input  logic [NUM_REQ*ADDR_W-1:0]   addr_i,
  input  logic [NUM_REQ*DATA_W-1:0]   wdata_i,
  output logic [NUM_REQ-1:0]          grant_o,
  output logic [NUM_REQ-1:0]          deny_o,
  output logic [NUM_REQ-1:0]          conflict_o,
  output logic [NUM_REQ*DATA_W-1:0]   rdata_o
);
  logic [NUM_REQ-1:0][ADDR_W-1:0] addr_a;
  logic [NUM_REQ-1:0][DATA_W-1:0] wdata_a;
  logic [NUM_REQ-1:0]             rd_v, wr_v;
  logic [NUM_REQ-1:0]             rd_first, rd_coll, wr_first, wr_coll;
  logic [NUM_REQ-1:0][NUM_REQ-1:0] wr_peer;
  logic [NUM_REQ-1:0][DATA_W-1:0] merged;
  logic [NUM_REQ-1:0]             merge_same;
  logic [NUM_REQ-1:0]             rd_gnt, wr_gnt, commit;
  logic [NUM_REQ-1:0][DATA_W-1:0] wr_val;
  policy_e                        pol;

  logic [DATA_W-1:0]              mem_q [DEPTH];
  logic [NUM_REQ-1:0][DATA_W-1:0] rdata_q;
  logic [NUM_REQ-1:0]             grant_q, deny_q, conflict_q;

  assign addr_a  = addr_i;
  assign wdata_a = wdata_i;
  assign wr_v    = wr_i;
  assign rd_v    = rd_i & ~wr_i;   // write wins when both are asserted
  assign pol     = policy_e'(policy_i);

  shmem_collide #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) u_collide (
    .rd_v_i     (rd_v),
    .wr_v_i     (wr_v),
    .addr_i     (addr_a),
    .rd_first_o (rd_first),
    .rd_coll_o  (rd_coll),
    .wr_first_o (wr_first),
    .wr_coll_o  (wr_coll),
    .wr_peer_o  (wr_peer)
  );

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_merge
    shmem_merge #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .LEAD(g)) u_merge (
      .peer_i   (wr_peer[g]),
      .wdata_i  (wdata_a),
      .policy_i (pol),
      .value_o  (merged[g]),
      .same_o   (merge_same[g])
    );
  end

  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) begin
      rd_gnt[i] = rd_v[i] & (mode_i[MODE_CRD] | rd_first[i]);
      if (!mode_i[MODE_CWR])      wr_gnt[i] = wr_v[i] & wr_first[i];
      else if (pol == POL_COMMON) wr_gnt[i] = wr_v[i] & merge_same[i];
      else                        wr_gnt[i] = wr_v[i];
      commit[i] = wr_gnt[i] & wr_first[i];  // one committer per word
      wr_val[i] = mode_i[MODE_CWR] ? merged[i] : wdata_a[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else begin
      for (int i = 0; i < NUM_REQ; i++)
        if (commit[i]) mem_q[addr_a[i]] <= wr_val[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q    <= '0;
      grant_q    <= '0;
      deny_q     <= '0;
      conflict_q <= '0;
    end else begin
      for (int i = 0; i < NUM_REQ; i++)
        rdata_q[i] <= rd_gnt[i] ? mem_q[addr_a[i]] : '0;
      grant_q    <= rd_gnt | wr_gnt;
      deny_q     <= (rd_v & ~rd_gnt) | (wr_v & ~wr_gnt);
      conflict_q <= (rd_v & rd_coll) | (wr_v & wr_coll);
    end
  end

  assign grant_o    = grant_q;
  assign deny_o     = deny_q;
  assign conflict_o = conflict_q;
  assign rdata_o    = rdata_q;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_chk
    assert_conc_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_v[g] && mode_i[MODE_CRD]) |=> grant_o[g]);
    assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rd_i[g] && !wr_i[g]) |=> !(grant_o[g] || deny_o[g] || conflict_o[g]));
    assert_gnt_deny_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(grant_o[g] && deny_o[g]));
    assert_deny_has_conflict_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      deny_o[g] |-> conflict_o[g]);
    assert_excl_write_loser_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_v[g] && !mode_i[MODE_CWR] && !wr_first[g]) |=> deny_o[g]);
    assert_common_mismatch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_v[g] && mode_i[MODE_CWR] && pol == POL_COMMON && !merge_same[g]) |=> deny_o[g]);
  end
endmodule

// File: tb/shmem_arbiter_bench.sv
module shmem_arbiter_bench;
  localparam int P  = 4;
  localparam int D  = 16;
  localparam int AW = 4;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rst_ni;
  logic [1:0]      mode_i;
  logic [2:0]      policy_i;
  logic [P-1:0]    rd_i, wr_i;
  logic [P*AW-1:0] addr_i;
  logic [P*DW-1:0] wdata_i;
  logic [P-1:0]    grant_o, deny_o, conflict_o;
  logic [P*DW-1:0] rdata_o;

  always #4 clk = ~clk;  // 125 MHz

  shmem_arbiter u_shmem_arbiter (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .policy_i(policy_i),
    .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .grant_o(grant_o), .deny_o(deny_o), .conflict_o(conflict_o), .rdata_o(rdata_o)
  );

  int    checks = 0;
  int    errors = 0;
  int    mem_m [D];
  string tag_m [D];
  int    rd_v [P], wr_v [P], a_v [P], d_v [P];
  int    mode_v, pol_v;

  task automatic check(int act, int exp, string tag, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle_all();
    for (int i = 0; i < P; i++) begin rd_v[i] = 0; wr_v[i] = 0; a_v[i] = 0; d_v[i] = 0; end
  endtask

  // one request cycle: drive, predict, wait, compare, update model
  task automatic step();
    int eg [P], ed [P], ec [P], er [P];
    string tg [P], tr [P];
    int nm [D];
    string nt [D];
    mode_i = 2'(mode_v); policy_i = 3'(pol_v);
    for (int i = 0; i < P; i++) begin
      rd_i[i] = rd_v[i][0]; wr_i[i] = wr_v[i][0];
      addr_i[i*AW +: AW] = AW'(a_v[i]);
      wdata_i[i*DW +: DW] = DW'(d_v[i]);
    end
    for (int i = 0; i < P; i++) begin
      int w, r, first, coll, g, eq;
      w = wr_v[i]; r = (rd_v[i] != 0 && w == 0) ? 1 : 0;
      first = 1; coll = 0; eq = 1; g = 0;
      tg[i] = "R2"; tr[i] = "R2"; er[i] = 0;
      for (int j = 0; j < P; j++) begin
        int rj;
        rj = (rd_v[j] != 0 && wr_v[j] == 0) ? 1 : 0;
        if (j != i && a_v[j] == a_v[i] && ((w != 0 && wr_v[j] != 0) || (r != 0 && rj != 0))) begin
          coll = 1;
          if (j < i) first = 0;
        end
        if (w != 0 && wr_v[j] != 0 && a_v[j] == a_v[i] && d_v[j] != d_v[i]) eq = 0;
      end
      if (r != 0) begin
        g = ((mode_v & 1) != 0) ? 1 : first;
        tg[i] = "R5";
        er[i] = g != 0 ? mem_m[a_v[i]] : 0;
        tr[i] = {tag_m[a_v[i]], " R3"};
      end else if (w != 0) begin
        if ((mode_v & 2) == 0) begin g = first; tg[i] = "R6"; end
        else if (pol_v == 1) begin g = eq; tg[i] = "R8"; end
        else begin g = 1; tg[i] = (pol_v == 2 || pol_v == 3) ? "R9" : (pol_v == 4 ? "R10" : "R7"); end
      end
      eg[i] = g;
      ed[i] = (r != 0 || w != 0) && g == 0 ? 1 : 0;
      ec[i] = coll;
    end
    for (int a = 0; a < D; a++) begin nm[a] = mem_m[a]; nt[a] = tag_m[a]; end
    for (int a = 0; a < D; a++) begin
      int q[$];
      int val, ok;
      string t;
      for (int i = 0; i < P; i++) if (wr_v[i] != 0 && a_v[i] == a) q.push_back(d_v[i]);
      if (q.size() == 0) continue;
      ok = 1; val = q[0];
      if ((mode_v & 2) == 0) t = "R6";
      else begin
        case (pol_v)
          1: begin t = "R8"; foreach (q[k]) if (q[k] != q[0]) ok = 0; end
          2: begin t = "R9"; foreach (q[k]) if (q[k] > val) val = q[k]; end
          3: begin t = "R9"; foreach (q[k]) if (q[k] < val) val = q[k]; end
          4: begin t = "R10"; val = 0; foreach (q[k]) val = (val + q[k]) % 65536; end
          default: t = "R7";
        endcase
      end
      if (ok != 0) begin nm[a] = val; nt[a] = t; end
    end
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < P; i++) begin
      check(int'(grant_o[i]), eg[i], tg[i], $sformatf("grant[%0d]", i));
      check(int'(deny_o[i]), ed[i], tg[i], $sformatf("deny[%0d]", i));
      check(int'(conflict_o[i]), ec[i], "R4", $sformatf("conflict[%0d]", i));
      check(int'(rdata_o[i*DW +: DW]), er[i], tr[i], $sformatf("rdata[%0d]", i));
    end
    for (int a = 0; a < D; a++) begin mem_m[a] = nm[a]; tag_m[a] = nt[a]; end
  endtask

  task automatic all_write(int addr, int d0, int d1, int d2, int d3);
    idle_all();
    for (int i = 0; i < P; i++) begin wr_v[i] = 1; a_v[i] = addr; end
    d_v[0] = d0; d_v[1] = d1; d_v[2] = d2; d_v[3] = d3;
    step();
  endtask

  task automatic all_read(int addr);
    idle_all();
    for (int i = 0; i < P; i++) begin rd_v[i] = 1; a_v[i] = addr; end
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; mode_i = '0; policy_i = '0; rd_i = '0; wr_i = '0; addr_i = '0; wdata_i = '0;
    for (int a = 0; a < D; a++) begin mem_m[a] = 0; tag_m[a] = "R1"; end
    idle_all(); mode_v = 0; pol_v = 0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    check(int'(grant_o), 0, "R1", "grant in reset");
    check(int'(deny_o), 0, "R1", "deny in reset");
    check(int'(conflict_o), 0, "R1", "conflict in reset");
    check(int'(rdata_o != '0), 0, "R1", "rdata in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: every word cleared, read through the ports in concurrent-read mode
    mode_v = 1;
    for (int b = 0; b < D / P; b++) begin
      idle_all();
      for (int i = 0; i < P; i++) begin rd_v[i] = 1; a_v[i] = b * P + i; end
      step();
    end
    // directed collisions in every discipline and policy
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 8; p++) begin
        mode_v = m; pol_v = p;
        all_write(5, 'hC001, 'h5000, 'h0003, 'h7000);  // R6 R7 R9 R10 wrap
        all_read(5);                                    // R5
        all_write(5, 'h0007, 'h0007, 'h0007, 'h0007);  // R8 equal data
        all_read(5);
        all_write(5, 'h0011, 'h0011, 'h0022, 'h0011);  // R8 mismatch
        all_read(5);
        // R3: read beside a write to the same word sees the old value
        idle_all();
        rd_v[0] = 1; a_v[0] = 5;
        wr_v[1] = 1; a_v[1] = 5; d_v[1] = 'h0099;
        wr_v[2] = 1; a_v[2] = 6; d_v[2] = 'h0003;
        wr_v[3] = 1; a_v[3] = 6; d_v[3] = 'hFFFF;
        rd_v[3] = 1;                                    // R2: write wins
        step();
        idle_all();
        rd_v[0] = 1; a_v[0] = 5; rd_v[1] = 1; a_v[1] = 5;
        rd_v[2] = 1; a_v[2] = 6; rd_v[3] = 1; a_v[3] = 7;
        step();
      end
    end
    // random traffic on a narrow address and data range
    for (int c = 0; c < 3000; c++) begin
      if (c % 50 == 0) begin mode_v = $urandom_range(0, 3); pol_v = $urandom_range(0, 7); end
      for (int i = 0; i < P; i++) begin
        int op;
        op = $urandom_range(0, 3);
        rd_v[i] = (op == 1 || op == 3) ? 1 : 0;
        wr_v[i] = (op >= 2) ? 1 : 0;
        a_v[i]  = $urandom_range(0, 3);
        d_v[i]  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 65535) : $urandom_range(0, 2);
      end
      step();
    end
    idle_all();
    step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule